// File: doc/BRIEF.md
# Three-Channel Sync Edge Skew Meter

This block measures how far apart in time the same transition arrives on three sync-on-green channel inputs. It works in cycles of a reference clock. On a high-to-low transition, skew is taken from channel 0 to channel 1 and from channel 1 to channel 2. On a low-to-high transition, the order reverses: channel 2 to channel 1, then channel 1 to channel 0. Each of the four skews is a small saturating count. The counts are packed two to a byte: one byte holds the falling-edge pair and one holds the rising-edge pair.

Each channel input is asynchronous. It passes through a flop synchroniser, and a one-cycle pulse marks each rising or falling transition. Four identical pair meters consume these pulses. Each pair meter is a two-state machine:

- **PAIR_ARMED** waits for the start edge. The transition ARMED→TIMING ("launch") happens on a start edge that has no stop edge in the same cycle. A start edge together with a stop edge records zero and leaves the meter in ARMED ("coincident").
- **PAIR_TIMING** counts clocks. The transition TIMING→ARMED happens in two ways. "capture" occurs when the stop edge arrives and records the count. "expire" occurs when the count reaches its ceiling and records the ceiling.

A synchronous clear sends every meter to ARMED ("flush") and zeroes all results.

Top module: `sog_skew_meter`

## Requirements
- R1: After reset, both `fall_skew` and `rise_skew` are 0x00.
- R2: `fall_skew[3:0]` holds the number of clock cycles from a channel 0 falling edge to the next channel 1 falling edge.
- R3: `fall_skew[7:4]` holds the number of clock cycles from a channel 1 falling edge to the next channel 2 falling edge.
- R4: `rise_skew[3:0]` holds the number of clock cycles from a channel 2 rising edge to the next channel 1 rising edge.
- R5: `rise_skew[7:4]` holds the number of clock cycles from a channel 1 rising edge to the next channel 0 rising edge.
- R6: When the start and stop transitions of a pair are sampled in the same clock cycle, that pair's field becomes 0.
- R7: If the stop edge arrives 15 or more cycles after the start edge, or never arrives, the field saturates at 15. The pair then re-arms and measures again from its next start edge.
- R8: A stop edge that arrives while its pair is waiting for a start edge leaves the field unchanged.
- R9: While `clr` is high at a clock edge, all four fields become 0 and every pair re-arms. Later edges are then measured normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all results and pair meters |
| sog_in | input | 3 | Asynchronous channel inputs, bit n is channel n |
| fall_skew | output | 2*CNT_W (8) | Falling-edge skews: [7:4] channel 1→2, [3:0] channel 0→1 |
| rise_skew | output | 2*CNT_W (8) | Rising-edge skews: [7:4] channel 1→0, [3:0] channel 2→1 |

## Verification
The bench builds the block with its defaults: two synchroniser stages and a 4-bit count. With a 4-bit count the ceiling is 15 cycles. The bench can therefore drive skews of 15 and 20 cycles within a short test, which reaches both saturation paths and the re-arm that follows. With the shallow synchroniser, edges driven on successive clocks stay distinct after synchronisation. This lets the bench produce single-cycle skews, zero skews and isolated stop edges, each with an exact expected count.

// File: rtl/sog_skew_pkg.sv
package sog_skew_pkg;

    localparam int NUM_CH    = 3;
    localparam int NUM_PAIRS = 4;

    typedef enum logic [0:0] {
        PAIR_ARMED  = 1'b0,
        PAIR_TIMING = 1'b1
    } pair_state_e;

    // Pair order: 0 = fall ch0->ch1, 1 = fall ch1->ch2,
    //             2 = rise ch2->ch1, 3 = rise ch1->ch0
    function automatic int pair_start_ch(input int p);
        case (p)
            0:       return 0;
            1:       return 1;
            2:       return 2;
            default: return 1;
        endcase
    endfunction

    function automatic int pair_stop_ch(input int p);
        case (p)
            0:       return 1;
            1:       return 2;
            2:       return 1;
            default: return 0;
        endcase
    endfunction

    function automatic bit pair_on_rise(input int p);
        return (p >= 2);
    endfunction

endpackage

// File: rtl/sog_edge_sync.sv
module sog_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise_pulse,
    output logic fall_pulse
);

    localparam int PIPE_W = SYNC_STAGES + 1;

    logic [PIPE_W-1:0] pipe_q;
    logic              cur_lvl;
    logic              old_lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= {pipe_q[PIPE_W-2:0], din};
        end
    end

    assign cur_lvl    = pipe_q[SYNC_STAGES-1];
    assign old_lvl    = pipe_q[SYNC_STAGES];
    assign rise_pulse = cur_lvl & ~old_lvl;
    assign fall_pulse = ~cur_lvl & old_lvl;

endmodule

// File: rtl/skew_pair_meter.sv
module skew_pair_meter
    import sog_skew_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             start_evt,
    input  logic             stop_evt,
    output logic [CNT_W-1:0] delay_q
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    pair_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PAIR_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: launch, coincident, capture, expire, flush
    always_comb begin
        state_d = state_q;
        if (clr) begin
            state_d = PAIR_ARMED;
        end else begin
            unique case (state_q)
                PAIR_ARMED: begin
                    if (start_evt && !stop_evt) state_d = PAIR_TIMING;
                end
                PAIR_TIMING: begin
                    if (stop_evt || cnt_q == CNT_MAX) state_d = PAIR_ARMED;
                end
                default: state_d = PAIR_ARMED;
            endcase
        end
    end

    // Counter and result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            delay_q <= '0;
        end else if (clr) begin
            cnt_q   <= '0;
            delay_q <= '0;
        end else begin
            unique case (state_q)
                PAIR_ARMED: begin
                    if (start_evt) cnt_q <= CNT_ONE;
                    if (start_evt && stop_evt) delay_q <= '0;
                end
                PAIR_TIMING: begin
                    if (stop_evt) begin
                        delay_q <= cnt_q;
                    end else if (cnt_q == CNT_MAX) begin
                        delay_q <= CNT_MAX;
                    end else begin
                        cnt_q <= cnt_q + CNT_ONE;
                    end
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    // R9
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (delay_q == '0 && state_q == PAIR_ARMED));

    // R2
    stop_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PAIR_TIMING && stop_evt && !clr) |=> (delay_q == $past(cnt_q)));

    // R7
    saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PAIR_TIMING && cnt_q == CNT_MAX && !clr)
        |=> (delay_q == CNT_MAX && state_q == PAIR_ARMED));

    // R6
    coincident_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PAIR_ARMED && start_evt && stop_evt && !clr) |=> (delay_q == '0));

    // R8
    idle_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PAIR_ARMED && stop_evt && !start_evt && !clr) |=> $stable(delay_q));

endmodule

// File: rtl/sog_skew_meter.sv
module sog_skew_meter
    import sog_skew_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic [2:0]         sog_in,
    output logic [2*CNT_W-1:0] fall_skew,
    output logic [2*CNT_W-1:0] rise_skew
);

    logic [NUM_CH-1:0] ch_rise;
    logic [NUM_CH-1:0] ch_fall;
    logic [CNT_W-1:0]  pair_delay [NUM_PAIRS];

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        sog_edge_sync #(
            .SYNC_STAGES (SYNC_STAGES)
        ) u_sync (
            .clk        (clk),
            .rst_n      (rst_n),
            .din        (sog_in[ch]),
            .rise_pulse (ch_rise[ch]),
            .fall_pulse (ch_fall[ch])
        );
    end

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        localparam int SC = pair_start_ch(p);
        localparam int EC = pair_stop_ch(p);
        logic start_evt;
        logic stop_evt;

        if (pair_on_rise(p)) begin : g_rise
            assign start_evt = ch_rise[SC];
            assign stop_evt  = ch_rise[EC];
        end else begin : g_fall
            assign start_evt = ch_fall[SC];
            assign stop_evt  = ch_fall[EC];
        end

        skew_pair_meter #(
            .CNT_W (CNT_W)
        ) u_meter (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (clr),
            .start_evt (start_evt),
            .stop_evt  (stop_evt),
            .delay_q   (pair_delay[p])
        );
    end

    assign fall_skew = {pair_delay[1], pair_delay[0]};
    assign rise_skew = {pair_delay[3], pair_delay[2]};

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (fall_skew == '0 && rise_skew == '0));

endmodule

// File: tb/tb_sog_skew_meter.sv
`timescale 1ns/1ps
module tb_sog_skew_meter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr = 1'b0;
    logic [2:0] sog_in = 3'b000;
    logic [7:0] fall_skew;
    logic [7:0] rise_skew;

    int n_checks = 0;
    int n_fails  = 0;

    typedef struct {
        logic [7:0] f;
        logic [7:0] r;
        string      tag;
    } exp_t;

    exp_t sb_q[$];
    event sample_ev;

    always #2 clk = ~clk;

    sog_skew_meter dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .sog_in    (sog_in),
        .fall_skew (fall_skew),
        .rise_skew (rise_skew)
    );

    task automatic gap(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_out(input logic [7:0] f, input logic [7:0] r, input string tag);
        exp_t item;
        gap(24);
        item.f = f;
        item.r = r;
        item.tag = tag;
        sb_q.push_back(item);
        ->sample_ev;
        #1;
    endtask

    // Monitor
    initial begin
        forever begin
            @(sample_ev);
            while (sb_q.size() > 0) begin
                exp_t it;
                it = sb_q.pop_front();
                n_checks++;
                if (fall_skew !== it.f) begin
                    n_fails++;
                    $display("FAIL %s fall_skew actual=%02h expected=%02h", it.tag, fall_skew, it.f);
                end
                n_checks++;
                if (rise_skew !== it.r) begin
                    n_fails++;
                    $display("FAIL %s rise_skew actual=%02h expected=%02h", it.tag, rise_skew, it.r);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(200000 * 4);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    // Driver
    initial begin
        gap(3);
        rst_n = 1'b1;
        expect_out(8'h00, 8'h00, "R1 reset");

        // R4 R5: rise 2 ->(4) 1 ->(6) 0
        sog_in[2] = 1'b1; gap(4);
        sog_in[1] = 1'b1; gap(6);
        sog_in[0] = 1'b1;
        expect_out(8'h00, 8'h64, "R4/R5 rise 4,6");

        // R2 R3: fall 0 ->(3) 1 ->(5) 2
        sog_in[0] = 1'b0; gap(3);
        sog_in[1] = 1'b0; gap(5);
        sog_in[2] = 1'b0;
        expect_out(8'h53, 8'h64, "R2/R3 fall 3,5");

        // R4 R5: rise 2 ->(2) 1 ->(7) 0
        sog_in[2] = 1'b1; gap(2);
        sog_in[1] = 1'b1; gap(7);
        sog_in[0] = 1'b1;
        expect_out(8'h53, 8'h72, "R4/R5 rise 2,7");

        // R7: ch0->ch1 after 20 saturates, ch1->ch2 gap 1
        sog_in[0] = 1'b0; gap(20);
        sog_in[1] = 1'b0; gap(1);
        sog_in[2] = 1'b0;
        expect_out(8'h1F, 8'h72, "R7 timeout / R3 one cycle");

        // R6: all rise together
        sog_in = 3'b111;
        expect_out(8'h1F, 8'h00, "R6 coincident");

        // R7: both exactly 15 and 16
        sog_in[0] = 1'b0; gap(15);
        sog_in[1] = 1'b0; gap(16);
        sog_in[2] = 1'b0;
        expect_out(8'hFF, 8'h00, "R7 at ceiling");

        // R8: isolated ch0 rise (stop of rise ch1->ch0 pair)
        sog_in[0] = 1'b1;
        expect_out(8'hFF, 8'h00, "R8 stop while armed");

        // R6 R7: ch2,ch1 rise together; ch1->ch0 never stops, then re-arm
        sog_in[2] = 1'b1;
        sog_in[1] = 1'b1;
        expect_out(8'hFF, 8'hF0, "R6/R7 never stops");

        // R9: clear
        clr = 1'b1; gap(1);
        clr = 1'b0;
        expect_out(8'h00, 8'h00, "R9 clear");

        // R9: measuring after clear
        sog_in[0] = 1'b0; gap(1);
        sog_in[1] = 1'b0; gap(14);
        sog_in[2] = 1'b0;
        expect_out(8'hE1, 8'h00, "R9 after clear / R2 R3");

        // R7 re-arm: rise pair ch1->ch0 measured again
        sog_in[2] = 1'b1; gap(3);
        sog_in[1] = 1'b1; gap(9);
        sog_in[0] = 1'b1;
        expect_out(8'hE1, 8'h93, "R7 rearm / R4 R5");

        gap(2);
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule